// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block decides which of four peripheral DMA channels owns the bus next. Each peripheral raises a request line that is not related to the arbiter clock. The arbiter passes every request through a two-flop synchroniser and masks it with that channel's enable bit, which comes from an 8-bit mode register that software can only write. It then picks one winner, using either fixed or rotating priority as the mode register selects.

When any enabled request is pending, the arbiter raises a hold request toward the processor. It grants nothing until the processor returns hold acknowledge. The winner's active-low acknowledge line stays low until the transfer engine pulses transfer-done. At that point the arbiter records the served channel for rotation and, if the stop-on-terminal-count mode is set and the transfer engine flags a terminal count, clears that channel's enable bit. It then arbitrates again from the updated state, or drops the hold request if nothing eligible remains.

The arbiter does not generate bus timing and does not count addresses. Those belong to neighbouring logic, which drives the transfer-done and terminal-count inputs.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After synchronous reset the mode register is zero, so all channels are disabled and priority is fixed. `hold_req` is 0 and `dack_n` is 4'b1111.
- R2: The mode register bit layout is as follows. Bit 4 selects rotating priority. Bit 6 selects stop-on-terminal-count. Bits 3..0 enable channels 3..0. Bit 7 (auto-reload) and bit 5 (extended write) are stored but do not change arbitration.
- R3: A request on a channel whose enable bit is 0 is ignored: it raises no `hold_req` and no acknowledge.
- R4: An enabled request raises `hold_req`. No `dack_n` line goes low until `hold_ack` has been sampled high.
- R5: With bit 4 = 0, the lowest-numbered eligible channel wins, so channel 0 is highest and channel 3 is lowest.
- R6: With bit 4 = 1, the search starts at the channel after the one served last, wrapping from 3 to 0. The channel just served is therefore lowest. The last-served channel after reset is 3.
- R7: At most one `dack_n` bit is low. It stays low and unchanged until `xfer_done` is sampled, and it is high in the following cycle.
- R8: When `xfer_done` and `xfer_tc` are both sampled high while bit 6 = 1, the served channel's enable bit is cleared, so that channel cannot win the next arbitration. With bit 6 = 0, the enable bit is kept.
- R9: When no enabled request remains after a transfer completes, `hold_req` falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq | input | 4 | Asynchronous request, one bit per channel |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| hold_ack | input | 1 | Hold acknowledge from the processor |
| xfer_done | input | 1 | Pulse: current transfer is complete |
| xfer_tc | input | 1 | Qualifies `xfer_done`: the transfer reached terminal count |
| hold_req | output | 1 | Hold request toward the processor |
| dack_n | output | 4 | Active-low acknowledge, one bit per channel |

## Verification
The bench sets up requests while `hold_ack` is low, which separates the synchroniser delay from arbitration. It checks the following cases:

- **Hold acknowledge:** it holds acknowledge off with enabled requests pending. A design that grants early would show an acknowledge low during that window.
- **Rotation:** it runs back-to-back transfers with all channels requesting under rotating priority. A rotation pointer that is not advanced, or is off by one, would repeat or skip a channel in the grant sequence.
- **Stop-on-terminal-count:** it completes transfers with and without the terminal count flag, under both settings of the stop bit. A design that clears enables late would grant the finished channel again. One that ignores the stop bit would clear an enable wrongly.
- **Randomised mixes:** random request, enable and priority combinations catch mask and wrap-around errors.
- **Last request finishes:** after the only request completes, the bench checks that `hold_req` falls.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int NCH = 4;
    localparam int CW  = $clog2(NCH);
    localparam int MW  = 4 + NCH;

    typedef struct packed {
        logic           autoload;
        logic           stop_tc;
        logic           ext_wr;
        logic           rotate;
        logic [NCH-1:0] en;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_GRANT = 2'd2
    } arb_st_e;

    typedef struct packed {
        logic          valid;
        logic [CW-1:0] ch;
    } pick_t;

    function automatic logic [CW-1:0] start_of(input logic rotate, input logic [CW-1:0] last);
        int s;
        s = rotate ? ((int'(last) + 1) % NCH) : 0;
        return CW'(s);
    endfunction

    function automatic pick_t pick_first(input logic [NCH-1:0] mask, input logic [CW-1:0] start);
        pick_t r;
        int    idx;
        r = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            idx = (int'(start) + k) % NCH;
            if (mask[idx]) begin
                r.valid = 1'b1;
                r.ch    = CW'(idx);
            end
        end
        return r;
    endfunction

    function automatic logic [NCH-1:0] onehot(input logic [CW-1:0] ch);
        logic [NCH-1:0] v;
        v = '0;
        v[ch] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/dma_arb_sync.sv
module dma_arb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-2:0], d[g]};
        end
        assign q[g] = sh[STAGES-1];
    end
endmodule

// File: rtl/dma_arb_mode.sv
module dma_arb_mode
    import dma_arb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [MW-1:0]  wdata,
    input  logic [NCH-1:0] clr_en,
    output mode_t          mode
);
    // A software write in the same cycle as a terminal-count clear wins.
    always_ff @(posedge clk) begin
        if (rst)      mode    <= '0;
        else if (wr)  mode    <= mode_t'(wdata);
        else          mode.en <= mode.en & ~clr_en;
    end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
    import dma_arb_pkg::*;
(
    input  logic [NCH-1:0] eligible,
    input  logic           rotate,
    input  logic [CW-1:0]  last,
    output logic           valid,
    output logic [CW-1:0]  win
);
    pick_t r;
    always_comb begin
        r     = pick_first(eligible, start_of(rotate, last));
        valid = r.valid;
        win   = r.ch;
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] dreq,
    input  logic           mode_wr,
    input  logic [MW-1:0]  mode_wdata,
    input  logic           hold_ack,
    input  logic           xfer_done,
    input  logic           xfer_tc,
    output logic           hold_req,
    output logic [NCH-1:0] dack_n
);
    logic [NCH-1:0] req_s;
    logic [NCH-1:0] eligible;
    logic [NCH-1:0] clr_en;
    mode_t          mode;
    arb_st_e        state, state_nx;
    logic [CW-1:0]  grant_ch, last_ch, win;
    logic           win_valid;
    logic           finish;

    dma_arb_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(dreq), .q(req_s)
    );

    dma_arb_mode u_mode (
        .clk(clk), .rst(rst), .wr(mode_wr), .wdata(mode_wdata),
        .clr_en(clr_en), .mode(mode)
    );

    assign eligible = req_s & mode.en;

    dma_arb_pick u_pick (
        .eligible(eligible), .rotate(mode.rotate), .last(last_ch),
        .valid(win_valid), .win(win)
    );

    assign finish = (state == ST_GRANT) && xfer_done;
    assign clr_en = (finish && xfer_tc && mode.stop_tc) ? onehot(grant_ch) : '0;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (|eligible) state_nx = ST_HOLD;
            ST_HOLD: begin
                if (!win_valid)    state_nx = ST_IDLE;
                else if (hold_ack) state_nx = ST_GRANT;
            end
            ST_GRANT: if (xfer_done) state_nx = ST_HOLD;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            grant_ch <= '0;
            last_ch  <= CW'(NCH - 1);
        end else begin
            state <= state_nx;
            if (state == ST_HOLD && hold_ack && win_valid) grant_ch <= win;
            if (finish) last_ch <= grant_ch;
        end
    end

    assign hold_req = (state != ST_IDLE);
    assign dack_n   = (state == ST_GRANT) ? ~onehot(grant_ch) : '1;

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk
    import dma_arb_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           hold_req,
    input logic           hold_ack,
    input logic           xfer_done,
    input logic [NCH-1:0] dack_n
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hold_req && dack_n == '1));

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dack_n));

    // R4
    grant_has_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dack_n != '1) |-> hold_req);

    // R4
    grant_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(dack_n) == '1 && dack_n != '1) |-> $past(hold_ack));

    // R7
    grant_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (dack_n != '1 && !xfer_done) |=> $stable(dack_n));

    // R7
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (dack_n != '1 && xfer_done) |=> (dack_n == '1));
endmodule

bind dma_prio_arbiter dma_arb_chk u_chk (
    .clk(clk), .rst(rst), .hold_req(hold_req), .hold_ack(hold_ack),
    .xfer_done(xfer_done), .dack_n(dack_n)
);

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] dreq = '0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic       hold_ack = 1'b0;
    logic       xfer_done = 1'b0;
    logic       xfer_tc = 1'b0;
    logic       hold_req;
    logic [3:0] dack_n;

    int checks = 0;
    int failures = 0;
    int exp_last = 3;

    always #2.5 clk = ~clk;

    dma_prio_arbiter i_dma_prio_arbiter (
        .clk(clk), .rst(rst), .dreq(dreq), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .hold_ack(hold_ack), .xfer_done(xfer_done),
        .xfer_tc(xfer_tc), .hold_req(hold_req), .dack_n(dack_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pick(input bit [3:0] m, input bit rot, input int last);
        int st;
        st = rot ? (last + 1) % 4 : 0;
        for (int k = 0; k < 4; k++)
            if (m[(st + k) % 4]) return (st + k) % 4;
        return -1;
    endfunction

    task automatic write_mode(input bit [7:0] v);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic setup(input bit [7:0] v, input bit [3:0] r);
        hold_ack = 1'b0;
        dreq = r;
        write_mode(v);
        repeat (6) @(negedge clk);
        hold_ack = 1'b1;
    endtask

    task automatic wait_grant(output int ch);
        ch = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dack_n != 4'hF) begin
                for (int j = 0; j < 4; j++) if (!dack_n[j]) ch = j;
                break;
            end
        end
    endtask

    task automatic finish_xfer(input int ch, input bit tc);
        @(negedge clk); xfer_done = 1'b1; xfer_tc = tc;
        @(negedge clk); xfer_done = 1'b0; xfer_tc = 1'b0;
        exp_last = ch;
    endtask

    task automatic grant_expect(input int exp, input string req, input bit tc);
        int ch;
        wait_grant(ch);
        chk(ch == exp, req, ch, exp);
        if (ch >= 0) finish_xfer(ch, tc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ch;
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(hold_req == 1'b0, "R1 hold_req", hold_req, 0);
        chk(dack_n == 4'hF, "R1 dack_n", dack_n, 15);
        // R1/R3 channels disabled after reset
        dreq = 4'hF; hold_ack = 1'b1;
        repeat (8) @(negedge clk);
        chk(hold_req == 1'b0, "R1 disabled after reset", hold_req, 0);

        // R3 requests only on disabled channels
        setup(8'h14, 4'b1011);
        repeat (8) @(negedge clk);
        chk(hold_req == 1'b0, "R3 masked hold", hold_req, 0);
        chk(dack_n == 4'hF, "R3 masked dack", dack_n, 15);

        // R4 hold raised, no grant while hold_ack low
        hold_ack = 1'b0; dreq = 4'hF;
        write_mode(8'h0F);
        repeat (8) @(negedge clk);
        chk(hold_req == 1'b1, "R4 hold_req", hold_req, 1);
        chk(dack_n == 4'hF, "R4 no grant before ack", dack_n, 15);
        hold_ack = 1'b1;
        grant_expect(0, "R5 first fixed", 1'b0);

        // R5 fixed priority repeats channel 0
        for (int i = 0; i < 3; i++) grant_expect(0, "R5 fixed repeat", 1'b0);
        setup(8'h0F, 4'b1100);
        grant_expect(2, "R5 fixed upper", 1'b0);

        // R6 rotating sequence with all requesting
        setup(8'h1F, 4'hF);
        for (int i = 0; i < 6; i++)
            grant_expect(exp_pick(4'hF, 1'b1, exp_last), "R6 rotate", 1'b0);

        // R2 autoload and extended-write bits have no effect on arbitration
        setup(8'hA2, 4'hF);
        grant_expect(1, "R2 ignored bits", 1'b0);

        // R8 stop on terminal count
        setup(8'h4F, 4'hF);
        grant_expect(0, "R8 tc first", 1'b1);
        grant_expect(1, "R8 ch0 cleared", 1'b1);
        grant_expect(2, "R8 ch1 cleared", 1'b0);
        grant_expect(2, "R8 no tc flag keeps", 1'b0);
        setup(8'h0F, 4'hF);
        grant_expect(0, "R8 stop bit off", 1'b1);
        grant_expect(0, "R8 enable kept", 1'b0);

        // R9 hold drops when last request finishes
        setup(8'h41, 4'b0001);
        grant_expect(0, "R9 single", 1'b1);
        repeat (4) @(negedge clk);
        chk(hold_req == 1'b0, "R9 hold dropped", hold_req, 0);
        chk(dack_n == 4'hF, "R9 no grant", dack_n, 15);

        // Random mixes: R3 R5 R6
        for (int it = 0; it < 40; it++) begin
            bit [3:0] rm, em;
            bit rot;
            int exp;
            rm = 4'($urandom % 16);
            em = 4'($urandom % 16);
            rot = 1'($urandom % 2);
            setup({3'b000, rot, em}, rm);
            exp = exp_pick(rm & em, rot, exp_last);
            if (exp < 0) begin
                repeat (8) @(negedge clk);
                chk(hold_req == 1'b0 && dack_n == 4'hF, "R3 random idle", hold_req, 0);
            end else begin
                grant_expect(exp, rot ? "R6 random" : "R5 random", 1'b0);
            end
        end

        hold_ack = 1'b0;
        repeat (4) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule